// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block gives an operating system a steady periodic tick. A 24-bit counter counts down from a software-chosen reload value. Each time it passes from one to zero it sets a sticky count flag, and if software has enabled the tick interrupt it pulses a request line toward the core's tick exception, number 15. On the next count after zero the counter reloads itself, so the tick period in counting steps equals the reload value plus one.

Each counting step comes either from the core clock, once per cycle, or from a rising edge of an external reference tick. The reference is resynchronised into the core clock domain before its edges are detected. While a debugger holds the core halted, counting stops. A read-only calibration word exposes a count that yields a tick of about 10 ms. Software can copy it into the reload register. It reads zero where the integration ties it low.

Software reaches four word registers through a simple single-cycle register bus. The bus carries byte offsets inside the system-control window.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current registers read 0 and `tick_req` is low.
- R2: The registers sit at byte offsets 0x010 (control), 0x014 (reload), 0x018 (current value) and 0x01C (calibration). Reads of any other offset return 0, and writes to them change nothing.
- R3: Control bit 0 enables counting. Bit 1 enables the tick request. Bit 2 selects the step source: 1 means the core clock and 0 means the external reference. These three bits read back as written. Bit 16 is the read-only count flag, and all other bits read 0.
- R4: While counting is enabled, each step decrements a non-zero current value by one. A step taken at zero loads the reload value (low 24 bits of the written word).
- R5: A step from 1 to 0 sets the count flag. If the tick request is enabled, `tick_req` goes high for exactly one cycle, in the cycle in which the current value first reads 0.
- R6: With the tick request disabled, `tick_req` stays low, and the count flag is still set by a 1-to-0 step.
- R7: A read of the control register returns the count flag and clears it afterwards. A flag set by a step on the same edge wins over the clear.
- R8: Any write to the current-value register, whatever its data, sets the counter to 0 and clears the count flag.
- R9: With a reload value of 0, the counter stays at 0 and never sets the flag.
- R10: In external mode the counter takes one step per rising edge of `ext_ref`, independent of the width of its high and low phases (each at least one clock cycle). In this mode the core clock alone causes no step.
- R11: While `dbg_halt` is high, the current value does not change except through a write to it.
- R12: The calibration register reads `cal_tenms` in bits 23:0 and zero above. Writes to it are ignored.
- R13: With counting disabled, the current value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the system-control window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| ext_ref | input | 1 | External reference tick, asynchronous |
| dbg_halt | input | 1 | Core halted by debugger |
| cal_tenms | input | 24 | Count for a tick of about 10 ms |
| tick_req | output | 1 | One-cycle tick exception request |

## Verification
A corrupted counter shows up in the current-value register on the very next step. A wrong reload or wrap decision makes `tick_req` appear one or more cycles off its arithmetic position within one period of at most reload+1 steps. A flag that is set or cleared wrongly shows up in the next control read. The sweeps compare the current value and `tick_req` every cycle against a model that is computed independently. Because of that, a defect in the counter or the flag logic is reported within the first tick period in which it matters. Errors in the synchroniser or edge detector change the number of steps that a counted burst of reference pulses produces.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_IE_BIT   = 1;
  localparam int unsigned CTL_SRC_BIT  = 2;
  localparam int unsigned CTL_FLAG_BIT = 16;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_CALIB   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic core_src;
    logic tick_ie;
    logic enable;
  } ctrl_t;

  // Next counter value for one counting step, on a 32-bit container.
  function automatic logic [31:0] step_value(input logic [31:0] cur, input logic [31:0] rel);
    return (cur == 32'd0) ? rel : cur - 32'd1;
  endfunction

  // A step taken at this value produces a tick.
  function automatic logic is_terminal(input logic [31:0] cur);
    return cur == 32'd1;
  endfunction

endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_rise
);
  localparam int unsigned LAST = SYNC_STAGES;

  logic [LAST:0] chain;

  generate
    for (genvar s = 0; s <= LAST; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= ref_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign ref_rise = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic             flag_rd_clr,
  input  logic             tick_ie,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cur,
  output logic             flag,
  output logic             wrap,
  output logic             tick_req
);
  logic [31:0] nxt_wide;
  logic [CNT_W-1:0] nxt;

  assign nxt_wide = step_value(32'(cur), 32'(reload));
  assign nxt      = nxt_wide[CNT_W-1:0];
  assign wrap     = step && !clear && is_terminal(32'(cur));

  wire unused_hi = ^nxt_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      flag     <= 1'b0;
      tick_req <= 1'b0;
    end else begin
      tick_req <= wrap && tick_ie;
      if (clear)     cur <= '0;
      else if (step) cur <= nxt;
      if (wrap)                      flag <= 1'b1;
      else if (clear || flag_rd_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned             ADDR_W    = 12,
  parameter int unsigned             CNT_W     = 24,
  parameter logic [ADDR_W-1:0]       BASE_ADDR = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [CNT_W-1:0]  cur,
  input  logic              flag,
  input  logic [CNT_W-1:0]  cal_tenms,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_wr,
  output logic              ctrl_rd
);
  localparam int unsigned IDX_LO = 2;
  localparam int unsigned WIN_LO = 4;

  logic     hit;
  reg_sel_e idx;

  assign hit = bus_sel && (bus_addr[ADDR_W-1:WIN_LO] == BASE_ADDR[ADDR_W-1:WIN_LO])
               && (bus_addr[IDX_LO-1:0] == '0);
  assign idx = reg_sel_e'(bus_addr[WIN_LO-1:IDX_LO]);

  assign cur_wr  = hit && bus_wr && (idx == REG_CURRENT);
  assign ctrl_rd = hit && !bus_wr && (idx == REG_CTRL);

  wire unused_base = ^BASE_ADDR[WIN_LO-1:0];
  wire unused_wd   = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
    end else if (hit && bus_wr) begin
      if (idx == REG_CTRL) begin
        ctrl.enable   <= bus_wdata[CTL_EN_BIT];
        ctrl.tick_ie  <= bus_wdata[CTL_IE_BIT];
        ctrl.core_src <= bus_wdata[CTL_SRC_BIT];
      end
      if (idx == REG_RELOAD) reload <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit && !bus_wr) begin
      unique case (idx)
        REG_CTRL: begin
          bus_rdata[CTL_EN_BIT]   = ctrl.enable;
          bus_rdata[CTL_IE_BIT]   = ctrl.tick_ie;
          bus_rdata[CTL_SRC_BIT]  = ctrl.core_src;
          bus_rdata[CTL_FLAG_BIT] = flag;
        end
        REG_RELOAD:  bus_rdata[CNT_W-1:0] = reload;
        REG_CURRENT: bus_rdata[CNT_W-1:0] = cur;
        REG_CALIB:   bus_rdata[CNT_W-1:0] = cal_tenms;
        default:     bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned       CNT_W       = 24,
  parameter int unsigned       ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 12'h010,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ext_ref,
  input  logic              dbg_halt,
  input  logic [CNT_W-1:0]  cal_tenms,
  output logic              tick_req
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cur;
  logic             flag;
  logic             cur_wr;
  logic             ctrl_rd;
  logic             ref_rise;
  logic             cnt_step;
  logic             wrap;

  tick_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur(cur), .flag(flag), .cal_tenms(cal_tenms),
    .ctrl(ctrl), .reload(reload), .cur_wr(cur_wr), .ctrl_rd(ctrl_rd)
  );

  tick_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_in(ext_ref), .ref_rise(ref_rise)
  );

  assign cnt_step = ctrl.enable && !dbg_halt && (ctrl.core_src ? 1'b1 : ref_rise);

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(cnt_step), .clear(cur_wr),
    .flag_rd_clr(ctrl_rd), .tick_ie(ctrl.tick_ie), .reload(reload),
    .cur(cur), .flag(flag), .wrap(wrap), .tick_req(tick_req)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_step,
  input logic             cur_wr,
  input logic             dbg_halt,
  input logic             enable,
  input logic             tick_ie,
  input logic             flag,
  input logic             tick_req,
  input logic [CNT_W-1:0] cur,
  input logic [CNT_W-1:0] reload
);
  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_step && !cur_wr && cur != '0 |=> cur == CNT_W'($past(cur) - 1'b1));

  // R4
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_step && !cur_wr && cur == '0 |=> cur == $past(reload));

  // R5
  tick_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_req |-> flag && cur == '0);

  // R5
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_req |=> !tick_req);

  // R6
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_req |-> $past(tick_ie));

  // R8
  cur_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> cur == '0 && !flag);

  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt && !cur_wr |=> $stable(cur));

  // R13
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !cur_wr |=> $stable(cur));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_step(cnt_step), .cur_wr(cur_wr),
  .dbg_halt(dbg_halt), .enable(ctrl.enable), .tick_ie(ctrl.tick_ie),
  .flag(flag), .tick_req(tick_req), .cur(cur), .reload(reload)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam time PERIOD = 20ns;
  localparam logic [11:0] A_CTRL = 12'h010, A_RLD = 12'h014, A_CUR = 12'h018, A_CAL = 12'h01C;
  localparam logic [31:0] FLAG = 32'h0001_0000;
  localparam logic [23:0] CAL_VAL = 24'h0F423F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_ref = 1'b0, dbg_halt = 1'b0;
  logic [23:0] cal_tenms = CAL_VAL;
  logic        tick_req;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_ref(ext_ref), .dbg_halt(dbg_halt), .cal_tenms(cal_tenms),
    .tick_req(tick_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, v1, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    bus_read(A_RLD, v);  check("R1 reload", v, 32'h0);
    bus_read(A_CUR, v);  check("R1 current", v, 32'h0);
    check("R1 tick_req", {31'b0, tick_req}, 32'h0);

    // R12 calibration
    bus_read(A_CAL, v); check("R12 cal", v, {8'h0, CAL_VAL});
    bus_write(A_CAL, 32'h1234_5678);
    bus_read(A_CAL, v); check("R12 cal write ignored", v, {8'h0, CAL_VAL});
    cal_tenms = '0;
    bus_read(A_CAL, v); check("R12 cal tied low", v, 32'h0);

    // R2 unmapped offsets
    bus_write(A_RLD, 32'hFF00_0007);
    bus_write(12'h00C, 32'h55);
    bus_write(12'h020, 32'h55);
    bus_read(A_RLD, v);    check("R2 reload kept", v, 32'h7);
    bus_read(12'h020, v);  check("R2 unmapped read", v, 32'h0);
    bus_read(A_CTRL, v);   check("R2 ctrl untouched", v, 32'h0);

    // R3 control bits read back
    bus_write(A_RLD, 32'd1000);
    bus_write(A_CTRL, 32'hFFFF_FFFF);
    bus_read(A_CTRL, v);   check("R3 ctrl readback", v, 32'h7);
    bus_write(A_CTRL, 32'h0);

    // R4 R5 R6 R7 R9 sweep of reload values, core clock
    for (int r = 0; r < 10; r++) begin
      automatic int m = 0;
      automatic logic ie = r[0];
      bus_write(A_RLD, r);
      bus_write(A_CUR, 32'hDEAD);
      bus_write(A_CTRL, {29'b0, 1'b1, ie, 1'b1});
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_CUR;
      for (int i = 1; i <= 25; i++) begin
        automatic int prev = m;
        @(negedge clk);
        #1;
        m = (m == 0) ? r : m - 1;
        check("R4 R9 current", bus_rdata, m);
        check("R5 R6 tick_req", {31'b0, tick_req}, {31'b0, ie && prev == 1});
      end
      @(negedge clk);
      bus_sel = 1'b0;
      bus_write(A_CTRL, 32'h0);
      bus_read(A_CTRL, v); check("R7 R9 flag first read", v, (r != 0) ? FLAG : 32'h0);
      bus_read(A_CTRL, v); check("R7 flag cleared by read", v, 32'h0);
    end

    // R8 current write clears counter and flag
    bus_write(A_RLD, 32'd2);
    bus_write(A_CUR, 32'h0);
    bus_write(A_CTRL, 32'h5);
    repeat (10) @(negedge clk);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_CUR, 32'h00AB_CDEF);
    bus_read(A_CUR, v);  check("R8 current cleared", v, 32'h0);
    bus_read(A_CTRL, v); check("R8 flag cleared", v, 32'h0);

    // R11 debug halt
    bus_write(A_RLD, 32'd1000);
    bus_write(A_CTRL, 32'h5);
    repeat (3) @(negedge clk);
    dbg_halt = 1'b1;
    bus_read(A_CUR, v1); check("R11 value at halt", v1, 32'd998);
    repeat (10) @(negedge clk);
    bus_read(A_CUR, v2); check("R11 held in halt", v2, v1);
    dbg_halt = 1'b0;
    repeat (5) @(negedge clk);
    bus_read(A_CUR, v);  check("R11 resumes", v, v1 - 32'd5);

    // R13 disabled hold
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CUR, v1);
    repeat (10) @(negedge clk);
    bus_read(A_CUR, v2); check("R13 held while disabled", v2, v1);

    // R10 external reference, pulse widths 1..3
    bus_write(A_RLD, 32'd50);
    bus_write(A_CTRL, 32'h3);
    for (int w = 1; w <= 3; w++) begin
      automatic int p = 4 + w;
      bus_write(A_CUR, 32'h0);
      repeat (10) @(negedge clk);
      bus_read(A_CUR, v); check("R10 no core-clock steps", v, 32'h0);
      for (int k = 0; k < p; k++) begin
        ext_ref = 1'b1;
        repeat (w) @(negedge clk);
        ext_ref = 1'b0;
        repeat (w) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      bus_read(A_CUR, v); check("R10 steps per edge", v, 32'd50 - (p - 1));
    end
    bus_write(A_CTRL, 32'h0);

    finish_run();
  end
endmodule